// File: doc/BRIEF.md
# Capture/Compare Timer with Two-Step Flag Clearing

The block is a 16-bit free-running timer reached over a small 8-bit register bus. It has two capture inputs and two compare outputs. Each capture input passes through a synchronizer. On a rising edge, the current count is latched into that channel's capture register. Each compare channel watches for the counter stepping onto its programmed value and then toggles its output pin. Counter wrap-around, both captures and both compare matches each raise a sticky flag in one 8-bit status register.

Software clears a flag in two steps. It first reads the status register. It then reads or writes the low byte of the data register that belongs to that flag. Only flags that were already set when the status register was read are armed for clearing, so an event that arrives between the two steps is not lost. A disable bit, writable only by software, freezes the counter and forces both compare outputs low. All registers stay accessible while the timer is disabled. Read data is registered and appears on the cycle after the read strobe.

Top module: `ccs_timer`

## Requirements
- R1: After a synchronous reset the status register reads 00h, both compare outputs are low and the counter restarts from 0000h.
- R2: The status register reads as {ICAP1 flag, CMP1 flag, WRAP flag, ICAP2 flag, CMP2 flag, disable, 0, 0}, from bit 7 down to bit 0. Bits 1:0 always read 0.
- R3: A rising edge on a capture input, seen after a two-flop synchronizer, latches the counter into that channel's capture register and sets that channel's capture flag (bit 7 for channel 1, bit 4 for channel 2).
- R4: When the counter steps onto the value of a compare register, that channel's compare flag sets (bit 6 for channel 1, bit 3 for channel 2) and its output pin toggles.
- R5: When the counter steps from FFFFh to 0000h, the wrap flag (bit 5) sets.
- R6: A flag clears only when a status read is followed by a read or write of its own low-byte register. The pairs are: capture-1 flag with address 6, compare-1 flag with address 10, wrap flag with address 2, capture-2 flag with address 8, compare-2 flag with address 12. An access to any other low byte leaves the flag set.
- R7: A read or write of the alternate counter low byte (address 4) never clears the wrap flag.
- R8: A flag that was 0 when the status register was read is not cleared by the next access to its low byte, even if it has set in the meantime.
- R9: If a flag's set event and its clearing access occur in the same cycle, the flag stays set.
- R10: While the disable bit is 1, the counter holds its value and both compare outputs are low. Compare and capture registers can still be read and written.
- R11: A write to the status register (address 0) changes only the disable bit, taken from bit 2 of the write data. The flags are not changed by that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter clock enable |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe, data valid next cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cap_in | input | 2 | Asynchronous capture inputs |
| ocmp | output | 2 | Compare outputs |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit bus and two synchronizer stages. With these values a full wrap of the counter fits inside one run, so the wrap flag and its clearing rules are tested on real roll-over. The disable bit freezes the counter at a known value, which gives exact expected capture values and a fixed place for compare matches. The two-stage synchronizer gives a fixed capture latency, so the bench can line up a capture event with a clearing access in the same cycle.

// File: rtl/ccs_timer_pkg.sv
package ccs_timer_pkg;
  localparam int ADDR_W = 4;
  localparam int NFLAG  = 5;

  // register addresses
  localparam logic [ADDR_W-1:0] A_STAT    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd2;
  localparam logic [ADDR_W-1:0] A_ALT_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_ALT_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP1_HI = 4'd5;
  localparam logic [ADDR_W-1:0] A_CAP1_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAP2_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAP2_LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_CMP1_HI = 4'd9;
  localparam logic [ADDR_W-1:0] A_CMP1_LO = 4'd10;
  localparam logic [ADDR_W-1:0] A_CMP2_HI = 4'd11;
  localparam logic [ADDR_W-1:0] A_CMP2_LO = 4'd12;

  // flag vector index; vector maps to status bits 7..3
  localparam int F_IC1 = 4;
  localparam int F_OC1 = 3;
  localparam int F_WRP = 2;
  localparam int F_IC2 = 1;
  localparam int F_OC2 = 0;
endpackage

// File: rtl/ccs_counter.sv
module ccs_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  assign wrap = step && (&cnt);

  // R10
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> (cnt == $past(cnt)));
endmodule

// File: rtl/ccs_capture.sv
module ccs_capture #(
  parameter int W     = 16,
  parameter int SYNC  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] value,
  output logic         event_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign event_o = sync_q[SYNC-1] && !prev_q;

  always_ff @(posedge clk) begin
    if (rst)          value <= '0;
    else if (event_o) value <= cnt;
  end
endmodule

// File: rtl/ccs_flags.sv
module ccs_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         stat_rd,
  input  logic [N-1:0] clr_acc,
  output logic [N-1:0] flags
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        arm_q[i] <= 1'b0;
      end else begin
        if (set_ev[i])                     flags[i] <= 1'b1;
        else if (clr_acc[i] && arm_q[i])   flags[i] <= 1'b0;
        if (stat_rd)         arm_q[i] <= flags[i];
        else if (clr_acc[i]) arm_q[i] <= 1'b0;
      end
    end

    // R6
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(arm_q[i] && clr_acc[i]));
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      $past(set_ev[i]) |-> flags[i]);
  end
endmodule

// File: rtl/ccs_timer.sv
module ccs_timer
  import ccs_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        cap_in,
  output logic [1:0]        ocmp
);
  localparam int NCH = 2;
  localparam int HI  = CNT_W - 1;
  localparam int LO  = DATA_W;

  logic             dis_q;
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] cap_val [NCH];
  logic [NCH-1:0]   cap_ev;
  logic [CNT_W-1:0] cmp_q   [NCH];
  logic [NCH-1:0]   match;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] set_ev;
  logic [NFLAG-1:0] clr_acc;
  logic             acc;
  logic             stat_rd;

  assign step = tick_en && !dis_q;
  assign acc  = rd_en || wr_en;
  assign stat_rd = rd_en && (addr == A_STAT);

  ccs_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .cnt(cnt), .wrap(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ccs_capture #(.W(CNT_W), .SYNC(SYNC)) u_cap (
      .clk(clk), .rst(rst), .pin(cap_in[c]), .cnt(cnt),
      .value(cap_val[c]), .event_o(cap_ev[c])
    );

    assign match[c] = step && ((cnt + 1'b1) == cmp_q[c]);

    always_ff @(posedge clk) begin
      if (rst || dis_q) ocmp[c] <= 1'b0;
      else if (match[c]) ocmp[c] <= !ocmp[c];
    end

    // R10
    out_low_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(dis_q) |-> !ocmp[c]);
  end

  // compare registers and disable bit
  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q    <= 1'b0;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
    end else if (wr_en) begin
      case (addr)
        A_STAT:    dis_q          <= wr_data[2];
        A_CMP1_HI: cmp_q[0][HI:LO] <= wr_data;
        A_CMP1_LO: cmp_q[0][LO-1:0] <= wr_data;
        A_CMP2_HI: cmp_q[1][HI:LO] <= wr_data;
        A_CMP2_LO: cmp_q[1][LO-1:0] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    set_ev        = '0;
    set_ev[F_IC1] = cap_ev[0];
    set_ev[F_OC1] = match[0];
    set_ev[F_WRP] = wrap;
    set_ev[F_IC2] = cap_ev[1];
    set_ev[F_OC2] = match[1];
    clr_acc        = '0;
    clr_acc[F_IC1] = acc && (addr == A_CAP1_LO);
    clr_acc[F_OC1] = acc && (addr == A_CMP1_LO);
    clr_acc[F_WRP] = acc && (addr == A_CNT_LO);
    clr_acc[F_IC2] = acc && (addr == A_CAP2_LO);
    clr_acc[F_OC2] = acc && (addr == A_CMP2_LO);
  end

  ccs_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_ev(set_ev), .stat_rd(stat_rd),
    .clr_acc(clr_acc), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (addr)
        A_STAT:    rd_data <= {flags, dis_q, 2'b00};
        A_CNT_HI, A_ALT_HI:   rd_data <= cnt[HI:LO];
        A_CNT_LO, A_ALT_LO:   rd_data <= cnt[LO-1:0];
        A_CAP1_HI: rd_data <= cap_val[0][HI:LO];
        A_CAP1_LO: rd_data <= cap_val[0][LO-1:0];
        A_CAP2_HI: rd_data <= cap_val[1][HI:LO];
        A_CAP2_LO: rd_data <= cap_val[1][LO-1:0];
        A_CMP1_HI: rd_data <= cmp_q[0][HI:LO];
        A_CMP1_LO: rd_data <= cmp_q[0][LO-1:0];
        A_CMP2_HI: rd_data <= cmp_q[1][HI:LO];
        A_CMP2_LO: rd_data <= cmp_q[1][LO-1:0];
        default:   rd_data <= '0;
      endcase
    end
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> (rd_data[1:0] == 2'b00));
  // R7
  alt_keeps_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && (addr == A_ALT_LO) && flags[F_WRP]) |=> flags[F_WRP]);
endmodule

// File: tb/tb_ccs_timer.sv
module tb_ccs_timer;
  import ccs_timer_pkg::*;

  logic       clk = 0;
  logic       rst = 1;
  logic       tick_en = 0;
  logic [3:0] addr = '0;
  logic       rd_en = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] cap_in = '0;
  logic [1:0] ocmp;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] c_frz;

  always #5 clk = ~clk;

  ccs_timer dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cap_in(cap_in), .ocmp(ocmp)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_cap(input int ch);
    cap_in[ch] = 1;
    repeat (4) @(negedge clk);
    cap_in[ch] = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(A_STAT, d);     check("R1 status", d, 8'h00);
    check("R1 ocmp", ocmp, 2'b00);
    bus_rd(A_CNT_HI, d);   check("R1 counter high", d, 8'h00);
  endtask

  task automatic t_freeze_capture();
    logic [7:0] d, h, l;
    bus_wr(A_STAT, 8'hFC);
    bus_rd(A_STAT, d);     check("R11 only disable bit written", d, 8'h04);
    bus_rd(A_CNT_HI, h); bus_rd(A_CNT_LO, l);
    c_frz = {h, l};
    repeat (6) @(negedge clk);
    bus_rd(A_CNT_HI, h); bus_rd(A_CNT_LO, l);
    check("R10 counter frozen", {h, l}, c_frz);
    pulse_cap(0);
    bus_rd(A_CAP1_HI, h); bus_rd(A_CAP1_LO, l);
    check("R3 capture value", {h, l}, c_frz);
    bus_rd(A_STAT, d);     check("R6 no clear without status read", d, 8'h84);
    bus_rd(A_CAP1_LO, l);
    bus_rd(A_STAT, d);     check("R6 capture-1 cleared", d, 8'h04);
  endtask

  task automatic t_pairing();
    logic [7:0] d;
    pulse_cap(1);
    bus_rd(A_STAT, d);     check("R3 capture-2 flag", d, 8'h14);
    bus_wr(A_CAP1_LO, 8'h00);
    bus_rd(A_STAT, d);     check("R6 wrong register keeps flag", d, 8'h14);
    bus_wr(A_CAP2_LO, 8'h00);
    bus_rd(A_STAT, d);     check("R6 capture-2 cleared by write", d, 8'h04);
  endtask

  task automatic t_arm();
    logic [7:0] d;
    bus_rd(A_STAT, d);
    pulse_cap(1);
    bus_wr(A_CAP2_LO, 8'h00);
    bus_rd(A_STAT, d);     check("R8 late flag survives", d, 8'h14);
    bus_rd(A_CAP2_LO, d);
    bus_rd(A_STAT, d);     check("R8 cleared after re-arm", d, 8'h04);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse_cap(0);
    bus_rd(A_STAT, d);     check("R3 capture-1 set again", d, 8'h84);
    cap_in[0] = 1;
    @(negedge clk); @(negedge clk);
    bus_rd(A_CAP1_LO, d);
    cap_in[0] = 0;
    repeat (4) @(negedge clk);
    bus_rd(A_STAT, d);     check("R9 set wins over clear", d, 8'h84);
    bus_rd(A_CAP1_LO, d);
    bus_rd(A_STAT, d);     check("R9 cleanup", d, 8'h04);
  endtask

  task automatic t_compare();
    logic [7:0] d;
    logic [15:0] v1, v2;
    v1 = c_frz + 16'd20; v2 = c_frz + 16'd30;
    bus_wr(A_CMP1_HI, v1[15:8]); bus_wr(A_CMP1_LO, v1[7:0]);
    bus_wr(A_CMP2_HI, v2[15:8]); bus_wr(A_CMP2_LO, v2[7:0]);
    bus_rd(A_CMP1_LO, d);  check("R10 register access while disabled", d, v1[7:0]);
    check("R10 ocmp low while disabled", ocmp, 2'b00);
    bus_wr(A_STAT, 8'h00);
    repeat (40) @(negedge clk);
    bus_rd(A_STAT, d);     check("R4 compare flags", d, 8'h48);
    check("R4 outputs toggled", ocmp, 2'b11);
    bus_wr(A_STAT, 8'h04);
    @(negedge clk);
    check("R10 outputs forced low", ocmp, 2'b00);
    bus_rd(A_STAT, d);
    bus_wr(A_CMP1_LO, v1[7:0]);
    bus_wr(A_CMP2_LO, v2[7:0]);
    bus_rd(A_STAT, d);     check("R6 compare flags cleared", d, 8'h04);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    bit seen = 0;
    bus_wr(A_STAT, 8'h00);
    for (int i = 0; i < 70000 && !seen; i++) begin
      bus_rd(A_STAT, d);
      if (d[5]) seen = 1;
    end
    check("R5 wrap flag set", {15'd0, seen}, 16'd1);
    bus_rd(A_CNT_HI, d);   check("R5 counter restarted", d, 8'h00);
    bus_rd(A_ALT_LO, d);
    bus_rd(A_STAT, d);     check("R7 alternate low keeps wrap", {15'd0, d[5]}, 16'd1);
    bus_rd(A_CNT_LO, d);
    bus_rd(A_STAT, d);     check("R6 wrap cleared by counter low", {15'd0, d[5]}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; tick_en = 1;
    t_reset();
    t_freeze_capture();
    t_pairing();
    t_arm();
    t_set_wins();
    t_compare();
    t_wrap();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule